// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns one internal read or write request into a transfer on a simple external bus. Each transfer has three phases. An address clock drives the address, the attributes, the chip selects and a one-clock start strobe. One or more data clocks follow, and they end when an acknowledge is seen. A hold clock then keeps the address, the attributes and any write data steady.

The acknowledge can come from two places. Each chip-select region is programmed with a base, a compare mask, a port width, an internal-acknowledge enable and a wait count. When the region has internal acknowledge enabled, a local counter ends the data phase after the programmed number of wait clocks. Otherwise the controller waits for the external acknowledge pin, guarded by an optional timeout.

An address that hits no region goes out as a plain 32-bit access with external acknowledge. An address that hits two regions, or hits a region while the DRAM-hit input is also set, is rejected with an error. A DRAM-only hit is reported as unsupported. A rejected request causes no bus activity.

Top module: `ebc_bus_master`

## Requirements
- R1: While reset is low and after it is released, `req_ready`=1, `busy`=0, `bus_ts`=0, `bus_cs`=0, `bus_doe`=0 and `rsp_valid`=0.
- R2: `bus_ts` is high for exactly one clock, in the clock after a request is accepted. `bus_addr`, `bus_wr` and `bus_size` carry the request from that clock through the hold clock.
- R3: On a read, `rsp_rdata` equals the `bus_din` value present at the rising edge where the acknowledge is taken. `rsp_valid` is high for the single hold clock.
- R4: On a write, `bus_doe`=1 and `bus_dout` equals the write data in every data clock and in the hold clock. `bus_doe` is 0 in the address clock, in idle clocks and on reads.
- R5: For a region with internal acknowledge enabled and wait count N (0..15), the data phase lasts exactly N+1 clocks, and `bus_ack_in` has no effect on it.
- R6: For an external-acknowledge access, the data phase repeats until the first clock in which `bus_ack_in`=1 is sampled, and it ends at that edge.
- R7: An address that hits no region and has `dram_hit`=0 runs with `bus_cs`=0, `bus_pw`=00 (32-bit) and external acknowledge.
- R8: An address that hits exactly one enabled region (bits where the mask is 1 equal the base) with `dram_hit`=0 asserts only that region's bit of `bus_cs` and drives that region's 2-bit width code on `bus_pw`.
- R9: An address that hits more than one region, or hits a region while `dram_hit`=1, gives one `rsp_valid` clock with `rsp_err`=01 and no `bus_ts` or `bus_cs`.
- R10: `dram_hit`=1 with no region hit gives one `rsp_valid` clock with `rsp_err`=10 and no bus activity.
- R11: For an external-acknowledge access with `to_limit`=L>0, if no acknowledge arrives in L data clocks, the cycle moves to the hold clock with `rsp_err`=11. With L=0 the controller waits indefinitely. `rsp_err`=00 marks success.
- R12: `req_ready` is high only in idle and hold clocks. A request accepted in the hold clock gets its address clock in the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_size | input | 2 | Transfer size attribute, passed through |
| req_wdata | input | DW | Write data |
| busy | output | 1 | A transfer or error response is in progress |
| rsp_valid | output | 1 | Response for the current request |
| rsp_err | output | 2 | 00 ok, 01 overlap, 10 DRAM unsupported, 11 timeout |
| rsp_rdata | output | DW | Read data |
| cfg_en | input | NREG | Region enables |
| cfg_base | input | NREG*AW | Region base addresses |
| cfg_mask | input | NREG*AW | Region compare masks (1 = compare) |
| cfg_pw | input | NREG*2 | Region port-width codes |
| cfg_int_ack | input | NREG | Region internal-acknowledge enables |
| cfg_wait | input | NREG*4 | Region wait counts |
| to_limit | input | TOW | External-acknowledge timeout in clocks, 0 = off |
| dram_hit | input | 1 | DRAM-region match for the request address |
| bus_addr | output | AW | External address |
| bus_size | output | 2 | External size attribute |
| bus_pw | output | 2 | External port-width attribute |
| bus_wr | output | 1 | External write strobe level |
| bus_ts | output | 1 | Transfer start |
| bus_cs | output | NREG | Chip selects |
| bus_dout | output | DW | Write data out |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DW | Read data in |
| bus_ack_in | input | 1 | External transfer acknowledge |

## Verification
Two situations are hard to reach from the ports. One is the edge where the timeout and a late external acknowledge compete. The other is a request accepted during the hold clock, which must start the next address clock with no idle clock in between. The stimulus makes the bench the bus slave. It withholds the acknowledge for a chosen number of data clocks, set both below and above the programmed timeout. It also presents a second request while the first response is still in its hold clock. Random traffic over overlapping and non-overlapping regions, with occasional DRAM hits, covers every decode outcome against a bench model of the region match.

// File: rtl/ebc_pkg.sv
// Shared types for the external bus cycle controller.
// Assumes a fixed 4-bit wait count and 2-bit port-width code per region.
package ebc_pkg;
    localparam int EBC_WAIT_W = 4;
    localparam int EBC_PW_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_HOLD = 3'd3,
        ST_ERR  = 3'd4
    } ebc_state_e;

    typedef enum logic [1:0] {
        RSP_OK      = 2'd0,
        RSP_OVERLAP = 2'd1,
        RSP_DRAM    = 2'd2,
        RSP_TIMEOUT = 2'd3
    } ebc_rsp_e;

    typedef struct packed {
        logic                  int_ack;
        logic [EBC_PW_W-1:0]   pw;
        logic [EBC_WAIT_W-1:0] waits;
    } ebc_attr_t;
endpackage

// File: rtl/ebc_region_match.sv
// Compares an address against every chip-select region and resolves the
// outcome: no hit, one hit, overlap, or DRAM-only hit.
// Assumes region fields are packed side by side, region 0 in the low bits.
module ebc_region_match
    import ebc_pkg::*;
#(
    parameter int NREG = 4,
    parameter int AW   = 32
) (
    input  logic [AW-1:0]      addr,
    input  logic [NREG-1:0]    cfg_en,
    input  logic [NREG*AW-1:0] cfg_base,
    input  logic [NREG*AW-1:0] cfg_mask,
    input  logic               dram_hit,
    output logic [NREG-1:0]    sel_cs,
    output ebc_rsp_e           dec_rsp
);
    localparam int CNTW = $clog2(NREG + 1);

    logic [NREG-1:0] hit;
    logic [CNTW-1:0] nhit;

    // One comparator per region: masked bits must equal the base.
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit[g] = cfg_en[g] &&
            (((addr ^ cfg_base[g*AW +: AW]) & cfg_mask[g*AW +: AW]) == '0);
    end

    // Population count of region hits.
    always_comb begin
        nhit = '0;
        for (int i = 0; i < NREG; i++) begin
            nhit = nhit + CNTW'(hit[i]);
        end
    end

    // Resolve the access class from hit count and DRAM match.
    always_comb begin
        sel_cs  = '0;
        dec_rsp = RSP_OK;
        if (dram_hit && nhit == '0) begin
            dec_rsp = RSP_DRAM;
        end else if (dram_hit || nhit > CNTW'(1)) begin
            dec_rsp = RSP_OVERLAP;
        end else begin
            sel_cs = hit;
        end
    end
endmodule

// File: rtl/ebc_attr_sel.sv
// Picks the attributes of the selected region, or the default external
// 32-bit, external-acknowledge attributes when no region is selected.
// Assumes sel_cs is one-hot or zero.
module ebc_attr_sel
    import ebc_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic [NREG-1:0]            sel_cs,
    input  logic [NREG*EBC_PW_W-1:0]   cfg_pw,
    input  logic [NREG-1:0]            cfg_int_ack,
    input  logic [NREG*EBC_WAIT_W-1:0] cfg_wait,
    output ebc_attr_t                  attr
);
    // Default attributes, overridden by the single selected region.
    always_comb begin
        attr = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel_cs[i]) begin
                attr.int_ack = cfg_int_ack[i];
                attr.pw      = cfg_pw[i*EBC_PW_W +: EBC_PW_W];
                attr.waits   = cfg_wait[i*EBC_WAIT_W +: EBC_WAIT_W];
            end
        end
    end
endmodule

// File: rtl/ebc_wait_timer.sv
// Counts data clocks and decides when the data phase ends: internal
// acknowledge after the wait count, external acknowledge from the pin, or
// a timeout when the external acknowledge is missing.
// Assumes clr is high for the clock before run starts.
module ebc_wait_timer
    import ebc_pkg::*;
#(
    parameter int TOW   = 8,
    parameter bit TO_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  run,
    input  logic                  int_ack_en,
    input  logic [EBC_WAIT_W-1:0] wait_n,
    input  logic                  ext_ack,
    input  logic [TOW-1:0]        to_limit,
    output logic                  ack_done,
    output logic                  tmo
);
    localparam int            CW      = (TOW > EBC_WAIT_W) ? TOW : EBC_WAIT_W;
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt;

    // Saturating count of completed data clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && cnt != CNT_MAX) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Acknowledge source chosen per region.
    assign ack_done = int_ack_en ? (cnt == CW'(wait_n)) : ext_ack;

    if (TO_EN) begin : g_tmo
        // Timeout applies only to external acknowledge; a late ack still wins.
        assign tmo = !int_ack_en && (to_limit != '0) && !ext_ack &&
                     (cnt == CW'(to_limit) - CW'(1));
    end else begin : g_no_tmo
        assign tmo = 1'b0;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX)) // R11
        else $error("wait counter wrapped");
endmodule

// File: rtl/ebc_bus_master.sv
// Top of the external bus cycle controller. Accepts one request at a time,
// decodes its region, then runs address, data (with wait states) and hold
// clocks on the external bus. Rejected requests answer without bus activity.
// Assumes configuration inputs are stable while a request is in flight.
module ebc_bus_master
    import ebc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NREG  = 4,
    parameter int TOW   = 8,
    parameter bit TO_EN = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [AW-1:0]              req_addr,
    input  logic [1:0]                 req_size,
    input  logic [DW-1:0]              req_wdata,
    output logic                       busy,
    output logic                       rsp_valid,
    output logic [1:0]                 rsp_err,
    output logic [DW-1:0]              rsp_rdata,
    input  logic [NREG-1:0]            cfg_en,
    input  logic [NREG*AW-1:0]         cfg_base,
    input  logic [NREG*AW-1:0]         cfg_mask,
    input  logic [NREG*EBC_PW_W-1:0]   cfg_pw,
    input  logic [NREG-1:0]            cfg_int_ack,
    input  logic [NREG*EBC_WAIT_W-1:0] cfg_wait,
    input  logic [TOW-1:0]             to_limit,
    input  logic                       dram_hit,
    output logic [AW-1:0]              bus_addr,
    output logic [1:0]                 bus_size,
    output logic [EBC_PW_W-1:0]        bus_pw,
    output logic                       bus_wr,
    output logic                       bus_ts,
    output logic [NREG-1:0]            bus_cs,
    output logic [DW-1:0]              bus_dout,
    output logic                       bus_doe,
    input  logic [DW-1:0]              bus_din,
    input  logic                       bus_ack_in
);
    ebc_state_e      state;
    ebc_rsp_e        dec_rsp;
    ebc_rsp_e        err_q;
    ebc_attr_t       dec_attr;
    ebc_attr_t       attr_q;
    logic [NREG-1:0] dec_cs;
    logic [NREG-1:0] cs_q;
    logic [AW-1:0]   addr_q;
    logic [1:0]      size_q;
    logic            wr_q;
    logic [DW-1:0]   wdata_q;
    logic [DW-1:0]   rdata_q;
    logic            accept;
    logic            on_bus;
    logic            ack_done;
    logic            tmo;

    ebc_region_match #(.NREG(NREG), .AW(AW)) u_match (
        .addr     (req_addr),
        .cfg_en   (cfg_en),
        .cfg_base (cfg_base),
        .cfg_mask (cfg_mask),
        .dram_hit (dram_hit),
        .sel_cs   (dec_cs),
        .dec_rsp  (dec_rsp)
    );

    ebc_attr_sel #(.NREG(NREG)) u_attr (
        .sel_cs      (dec_cs),
        .cfg_pw      (cfg_pw),
        .cfg_int_ack (cfg_int_ack),
        .cfg_wait    (cfg_wait),
        .attr        (dec_attr)
    );

    ebc_wait_timer #(.TOW(TOW), .TO_EN(TO_EN)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (state == ST_ADDR),
        .run        (state == ST_DATA),
        .int_ack_en (attr_q.int_ack),
        .wait_n     (attr_q.waits),
        .ext_ack    (bus_ack_in),
        .to_limit   (to_limit),
        .ack_done   (ack_done),
        .tmo        (tmo)
    );

    // Handshake: a new request may enter while idle or during the hold clock.
    assign req_ready = (state == ST_IDLE) || (state == ST_HOLD);
    assign accept    = req_valid && req_ready;
    assign busy      = (state != ST_IDLE);
    assign on_bus    = (state == ST_ADDR) || (state == ST_DATA) || (state == ST_HOLD);

    // Bus cycle sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE, ST_HOLD: begin
                    if (accept) begin
                        state <= (dec_rsp == RSP_OK) ? ST_ADDR : ST_ERR;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_ADDR: state <= ST_DATA;
                ST_DATA: begin
                    if (ack_done || tmo) begin
                        state <= ST_HOLD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request capture at acceptance, read data and status at data-phase end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            cs_q    <= '0;
            attr_q  <= '0;
            err_q   <= RSP_OK;
            rdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            size_q  <= req_size;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            cs_q    <= dec_cs;
            attr_q  <= dec_attr;
            err_q   <= dec_rsp;
        end else if (state == ST_DATA) begin
            if (ack_done) begin
                rdata_q <= bus_din;
            end else if (tmo) begin
                err_q <= RSP_TIMEOUT;
            end
        end
    end

    // External pin drive from captured request and phase.
    assign bus_ts    = (state == ST_ADDR);
    assign bus_addr  = addr_q;
    assign bus_size  = size_q;
    assign bus_pw    = attr_q.pw;
    assign bus_wr    = wr_q && on_bus;
    assign bus_cs    = on_bus ? cs_q : '0;
    assign bus_doe   = wr_q && ((state == ST_DATA) || (state == ST_HOLD));
    assign bus_dout  = wdata_q;
    assign rsp_valid = (state == ST_HOLD) || (state == ST_ERR);
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;

    AST_TS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ts |=> !bus_ts) // R2
        else $error("start strobe longer than one clock");

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA || state == ST_HOLD) |-> $stable(bus_addr)) // R2
        else $error("address moved during cycle");

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_cs)) // R8
        else $error("more than one chip select");

    AST_DOE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> bus_wr) // R4
        else $error("data driven on a read");

    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe)) |-> $stable(bus_dout)) // R4
        else $error("write data moved while driven");

    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERR) |-> (!bus_ts && bus_cs == '0 && !bus_doe)) // R9
        else $error("bus activity on rejected request");

    AST_READY_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ts |-> !req_ready) // R12
        else $error("ready during address clock");
endmodule

// File: tb/ebc_bus_master_tb.sv
// Self-checking bench: acts as requester and as external bus slave.
module ebc_bus_master_tb;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int NREG = 4;
    localparam int TOW  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst_n;
    logic                 req_valid, req_ready, req_write, busy;
    logic [AW-1:0]        req_addr;
    logic [1:0]           req_size;
    logic [DW-1:0]        req_wdata;
    logic                 rsp_valid;
    logic [1:0]           rsp_err;
    logic [DW-1:0]        rsp_rdata;
    logic [NREG-1:0]      cfg_en;
    logic [NREG*AW-1:0]   cfg_base, cfg_mask;
    logic [NREG*2-1:0]    cfg_pw;
    logic [NREG-1:0]      cfg_int_ack;
    logic [NREG*4-1:0]    cfg_wait;
    logic [TOW-1:0]       to_limit;
    logic                 dram_hit;
    logic [AW-1:0]        bus_addr;
    logic [1:0]           bus_size, bus_pw;
    logic                 bus_wr, bus_ts, bus_doe, bus_ack_in;
    logic [NREG-1:0]      bus_cs;
    logic [DW-1:0]        bus_dout, bus_din;

    logic [31:0] rb [NREG];
    logic [31:0] rm [NREG];
    logic [1:0]  rpw[NREG];
    logic        rint[NREG];
    logic [3:0]  rwt[NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_cfg
        assign cfg_base[g*AW +: AW] = rb[g];
        assign cfg_mask[g*AW +: AW] = rm[g];
        assign cfg_pw[g*2 +: 2]     = rpw[g];
        assign cfg_int_ack[g]       = rint[g];
        assign cfg_wait[g*4 +: 4]   = rwt[g];
    end

    ebc_bus_master #(.AW(AW), .DW(DW), .NREG(NREG), .TOW(TOW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cfg_en(cfg_en),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_pw(cfg_pw),
        .cfg_int_ack(cfg_int_ack), .cfg_wait(cfg_wait), .to_limit(to_limit),
        .dram_hit(dram_hit), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_pw(bus_pw), .bus_wr(bus_wr), .bus_ts(bus_ts), .bus_cs(bus_cs),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_ack_in(bus_ack_in)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Next request presented during a hold clock (back-to-back case).
    logic        nx_wr, nx_dram;
    logic [31:0] nx_addr, nx_wd;
    logic [1:0]  nx_sz;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Bench model of region resolution: 0 default, 1 region, 2 overlap, 3 DRAM.
    function automatic int exp_kind(input logic [31:0] a, input logic d, output int idx);
        int nh = 0;
        idx = 0;
        for (int i = 0; i < NREG; i++) begin
            if (((a ^ rb[i]) & rm[i]) == 32'h0) begin
                nh++;
                idx = i;
            end
        end
        if (d && nh == 0) return 3;
        if (d || nh > 1)  return 2;
        if (nh == 1)      return 1;
        return 0;
    endfunction

    task automatic do_txn(input logic wr, input logic [31:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input logic dram, input int ack_after,
                          input bit pre, input bit chain);
        int          idx;
        int          kind;
        int          exp_n;
        int          n;
        int          lim;
        bit          intk;
        logic [1:0]  exp_err;
        logic [1:0]  exp_pw;
        logic [3:0]  exp_cs;
        logic [31:0] rd;
        string       tag;
        kind = exp_kind(addr, dram, idx);
        rd   = $urandom;
        lim  = int'(to_limit);
        if (!pre) begin
            @(negedge clk);
            req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
            dram_hit = dram; req_valid = 1'b1;
            chk(req_ready == 1'b1, "R12 ready when idle", 32'(req_ready), 32'd1);
            @(posedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (kind >= 2) begin
            exp_err = (kind == 3) ? 2'b10 : 2'b01;
            tag = (kind == 3) ? "R10 dram response" : "R9 overlap response";
            chk(rsp_valid && rsp_err == exp_err, tag, {30'd0, rsp_err}, {30'd0, exp_err});
            chk(!bus_ts && bus_cs == 4'd0 && !bus_doe, kind == 3 ? "R10 no bus" : "R9 no bus",
                {28'd0, bus_cs}, 32'd0);
            @(posedge clk);
            return;
        end
        exp_cs = (kind == 1) ? 4'(1 << idx) : 4'd0;
        exp_pw = (kind == 1) ? rpw[idx] : 2'b00;
        intk   = (kind == 1) && rint[idx];
        if (intk) begin
            exp_n = int'(rwt[idx]) + 1; exp_err = 2'b00;
        end else if (lim != 0 && ack_after > lim) begin
            exp_n = lim; exp_err = 2'b11;
        end else begin
            exp_n = ack_after; exp_err = 2'b00;
        end
        // Address clock.
        chk(bus_ts == 1'b1, "R2 start strobe", 32'(bus_ts), 32'd1);
        chk(bus_addr == addr && bus_wr == wr && bus_size == sz, "R2 address clock",
            bus_addr, addr);
        chk(bus_cs == exp_cs, kind == 1 ? "R8 chip select" : "R7 no chip select",
            {28'd0, bus_cs}, {28'd0, exp_cs});
        chk(bus_pw == exp_pw, kind == 1 ? "R8 port width" : "R7 port width",
            {30'd0, bus_pw}, {30'd0, exp_pw});
        chk(bus_doe == 1'b0, "R4 no drive in address clock", 32'(bus_doe), 32'd0);
        chk(req_ready == 1'b0, "R12 not ready in address clock", 32'(req_ready), 32'd0);
        // Data clocks; bench plays the slave.
        n = 0;
        forever begin
            @(posedge clk);
            @(negedge clk);
            if (rsp_valid || n > 400) break;
            n++;
            chk(!bus_ts && bus_doe == wr, "R4 data clock drive", 32'(bus_doe), 32'(wr));
            if (wr) chk(bus_dout == wd, "R4 write data", bus_dout, wd);
            if (intk) begin
                bus_ack_in = 1'b1;
                bus_din    = (n == exp_n) ? rd : $urandom;
            end else begin
                bus_ack_in = (n == ack_after);
                bus_din    = (n == ack_after) ? rd : $urandom;
            end
        end
        bus_ack_in = 1'b0;
        // Hold clock.
        tag = intk ? "R5 internal wait length" : (exp_err == 2'b11 ? "R11 timeout length"
                                                                    : "R6 external wait length");
        chk(n == exp_n, tag, 32'(n), 32'(exp_n));
        chk(rsp_valid && rsp_err == exp_err, exp_err == 2'b11 ? "R11 timeout code" : "R3 ok code",
            {30'd0, rsp_err}, {30'd0, exp_err});
        if (!wr && exp_err == 2'b00) chk(rsp_rdata == rd, "R3 read data", rsp_rdata, rd);
        chk(bus_doe == wr, "R4 hold clock drive", 32'(bus_doe), 32'(wr));
        if (wr) chk(bus_dout == wd, "R4 hold write data", bus_dout, wd);
        chk(bus_addr == addr && bus_cs == exp_cs && !bus_ts, "R2 hold clock", bus_addr, addr);
        chk(req_ready == 1'b1, "R12 ready in hold", 32'(req_ready), 32'd1);
        if (chain) begin
            req_write = nx_wr; req_addr = nx_addr; req_size = nx_sz; req_wdata = nx_wd;
            dram_hit = nx_dram; req_valid = 1'b1;
            @(posedge clk);
        end else begin
            @(posedge clk);
            @(negedge clk);
            chk(!rsp_valid && !busy && !bus_doe && bus_cs == 4'd0, "R4 idle after cycle",
                {31'd0, busy}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
        req_wdata = '0; dram_hit = 1'b0; bus_din = '0; bus_ack_in = 1'b0;
        to_limit = '0; cfg_en = 4'hF;
        rb[0] = 32'h1000_0000; rm[0] = 32'hFF00_0000; rpw[0] = 2'b01; rint[0] = 1'b1; rwt[0] = 4'd0;
        rb[1] = 32'h2000_0000; rm[1] = 32'hFF00_0000; rpw[1] = 2'b10; rint[1] = 1'b0; rwt[1] = 4'd0;
        rb[2] = 32'h3000_0000; rm[2] = 32'hFF00_0000; rpw[2] = 2'b11; rint[2] = 1'b1; rwt[2] = 4'd5;
        rb[3] = 32'h3080_0000; rm[3] = 32'hFFF0_0000; rpw[3] = 2'b01; rint[3] = 1'b1; rwt[3] = 4'd2;
        repeat (3) @(negedge clk);
        chk(req_ready && !busy && !bus_ts && bus_cs == 4'd0 && !bus_doe && !rsp_valid,
            "R1 state in reset", {31'd0, busy}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy && !bus_ts && bus_cs == 4'd0 && !bus_doe && !rsp_valid,
            "R1 state after reset", {31'd0, busy}, 32'd0);

        // Directed corner cases.
        do_txn(1'b0, 32'h1000_0040, 2'b10, 32'h0, 1'b0, 1, 1'b0, 1'b0); // R5 zero waits
        do_txn(1'b1, 32'h2000_1234, 2'b01, 32'hA5A5_0F0F, 1'b0, 3, 1'b0, 1'b0); // R6
        do_txn(1'b0, 32'h5000_0000, 2'b10, 32'h0, 1'b0, 2, 1'b0, 1'b0); // R7
        do_txn(1'b0, 32'h3080_1234, 2'b10, 32'h0, 1'b0, 1, 1'b0, 1'b0); // R9 overlap
        do_txn(1'b0, 32'h1000_0000, 2'b10, 32'h0, 1'b1, 1, 1'b0, 1'b0); // R9 with DRAM
        do_txn(1'b0, 32'h5000_0000, 2'b10, 32'h0, 1'b1, 1, 1'b0, 1'b0); // R10
        to_limit = 8'd5;
        do_txn(1'b0, 32'h2000_0008, 2'b10, 32'h0, 1'b0, 8, 1'b0, 1'b0); // R11 timeout
        do_txn(1'b0, 32'h2000_000C, 2'b10, 32'h0, 1'b0, 5, 1'b0, 1'b0); // R11 ack at limit
        to_limit = 8'd0;
        do_txn(1'b0, 32'h2000_0010, 2'b10, 32'h0, 1'b0, 9, 1'b0, 1'b0); // R11 disabled
        rwt[2] = 4'd15;
        do_txn(1'b1, 32'h3000_0100, 2'b00, 32'h1234_5678, 1'b0, 1, 1'b0, 1'b0); // R5 max waits
        rwt[2] = 4'd5;
        nx_wr = 1'b1; nx_addr = 32'h2000_0020; nx_sz = 2'b10; nx_wd = 32'hDEAD_BEEF; nx_dram = 1'b0;
        do_txn(1'b0, 32'h3000_0200, 2'b10, 32'h0, 1'b0, 1, 1'b0, 1'b1); // R12 back to back
        do_txn(nx_wr, nx_addr, nx_sz, nx_wd, nx_dram, 2, 1'b1, 1'b0);

        // Constrained random traffic.
        to_limit = 8'd6;
        for (int k = 0; k < 60; k++) begin
            logic [31:0] a;
            int          sel;
            sel = int'($urandom % 6);
            case (sel)
                0: a = {8'h10, 24'($urandom)};
                1: a = {8'h20, 24'($urandom)};
                2: a = {8'h30, 1'b0, 23'($urandom)};
                3: a = {12'h308, 20'($urandom)};
                4: a = {8'h50, 24'($urandom)};
                default: a = {8'h7F, 24'($urandom)};
            endcase
            do_txn(1'($urandom), a, 2'($urandom), $urandom, ($urandom % 8) == 0,
                   1 + int'($urandom % 7), 1'b0, 1'b0);
        end

        report();
        $finish;
    end
endmodule